// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block decides when a newly written preamplifier gain becomes the gain that is actually applied, and what that gain is. A 6-bit gain code arrives with a one-cycle load strobe. The block converts the code to a gain in dB and stores it. It then updates a registered applied-gain output, either at once or at the next sign change of the amplified signal. A down-counter puts an upper bound on how long a deferred change can wait for a sign change.

Three asynchronous pins are brought into the clock domain through synchroniser chains. These are the unity-gain override, the zero-crossing mode enable and the sign bit of the signal. While the override is high, the output is forced to 0 dB, but software can still write new codes. When the override drops, the stored gain is released under the same zero-crossing rule as a normal write. Only the integer dB value is produced here; switching the analog gain network is done elsewhere.

Top module: `zc_gain_ctrl`

## Requirements
- R1: The code N maps to a gain as follows: N = 0 gives 0 dB, N from 1 to 56 gives N + 9 dB, and N from 57 to 63 gives 65 dB. The output never exceeds 65.
- R2: With zero-crossing mode off, a load changes the output on the same clock edge that captures the strobe.
- R3: With zero-crossing mode on, a load only marks a change as pending, and the output holds its old value. A sign change of the signal input applies the pending gain on the third rising edge after the pin toggles (two synchroniser stages, then the update register). This holds for both directions of the sign change.
- R4: If no sign change occurs, a pending change is applied exactly TIMEOUT_CYC clock edges after the edge that captured the load.
- R5: A load while a change is pending replaces the pending value and restarts the timeout from that load.
- R6: While the unity pin is high, the output is 0. It reaches 0 on the third rising edge after the pin rises, and any pending change is dropped.
- R7: Loads made while the unity pin is high update the stored gain but leave the output at 0.
- R8: When the unity pin falls, the stored gain is applied. With zero-crossing mode off, this happens on the third edge after the fall. With the mode on, the output stays at 0 until a sign change or a timeout.
- R9: If zero-crossing mode is turned off while a change is pending, the change is applied on the third edge after the mode pin falls.
- R10: After reset, the output is 0, the stored gain is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_i | input | 6 | Gain code, sampled when load_i is high |
| load_i | input | 1 | One-cycle strobe: a new gain code is present |
| unity_i | input | 1 | Asynchronous override pin, forces 0 dB while high |
| zc_en_i | input | 1 | Asynchronous zero-crossing mode enable |
| sign_i | input | 1 | Asynchronous sign bit of the amplified signal |
| gain_db_o | output | 7 | Applied gain in dB |

## Verification
The bench walks the code map across its edges: 0, 1, 56, 57 and 63. A design that shifts the offset or saturates at the wrong code produces a wrong dB value there. Deferred updates are sampled one cycle before and one cycle after the expected edge, for a rising sign change, a falling sign change, a timeout, a replacement load and a mode drop. An off-by-one counter, a missing synchroniser stage or a timer that does not restart therefore shows up as a value that arrives early or late. The override tests write a code while the override is held and then release the pin in each mode. A design that lets the write through, loses it, or skips the zero-crossing hold on release reports a wrong gain.

// File: rtl/zcg_pkg.sv
// Package: shared widths and the code-to-dB map for the gain update controller.
// Assumes codes are unsigned and that the dB value fits in DB_W bits.
package zcg_pkg;
    localparam int CODE_W      = 6;
    localparam int DB_W        = 7;
    localparam int LIN_OFFSET  = 9;   // dB added to codes in the linear range
    localparam int LIN_TOP     = 56;  // last code of the linear range
    localparam int MAX_DB      = LIN_OFFSET + LIN_TOP;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [DB_W-1:0]   db_t;

    // Convert a gain code to dB: zero is unity, the linear range is offset, and codes above it saturate.
    function automatic db_t code_to_db(input code_t c);
        db_t r;
        if (c == '0)
            r = '0;
        else if (int'(c) > LIN_TOP)
            r = db_t'(MAX_DB);
        else
            r = db_t'(c) + db_t'(LIN_OFFSET);
        return r;
    endfunction
endpackage

// File: rtl/zcg_sync.sv
// Module: zcg_sync
// Brings W asynchronous pins into the clk domain through a STAGES-deep flop chain.
// Assumes each pin is held long enough to be seen by at least one clock edge.
module zcg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_i;
            end
        end else begin : g_multi
            // Shift the pins down the chain, with the oldest sample at the top.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[CHAIN_W-W-1:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/zcg_events.sv
// Module: zcg_events
// Turns synchronised levels into one-cycle events: a sign change (zero crossing)
// and the release of the unity override. Assumes inputs are already synchronous.
module zcg_events (
    input  logic clk,
    input  logic rst_n,
    input  logic sign_s,
    input  logic unity_s,
    output logic zc_evt_o,
    output logic unity_rel_o
);
    logic sign_q;
    logic unity_q;

    // Keep the previous sample of each level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q  <= 1'b0;
            unity_q <= 1'b0;
        end else begin
            sign_q  <= sign_s;
            unity_q <= unity_s;
        end
    end

    assign zc_evt_o    = sign_s ^ sign_q;
    assign unity_rel_o = unity_q & ~unity_s;
endmodule

// File: rtl/zcg_timeout.sv
// Module: zcg_timeout
// Down-counter that bounds how long a pending change may wait. It reloads on
// start_i and signals expiry once it reaches zero while a change is pending.
// Assumes TIMEOUT_CYC >= 1.
module zcg_timeout #(
    parameter int TIMEOUT_CYC = 4_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic pending_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Reload on a new request, otherwise count down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start_i)
            cnt <= RELOAD;
        else if (pending_i && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire_o = pending_i && (cnt == '0);
endmodule

// File: rtl/zcg_update.sv
// Module: zcg_update
// Holds the stored gain, the pending flag and the applied gain, and decides on
// each edge whether the applied gain changes. The override has priority, then a
// new request, then the resolution of a pending change. Assumes load_i is a
// synchronous single-cycle strobe.
module zcg_update
    import zcg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  code_t code_i,
    input  logic  unity_s,
    input  logic  zc_en_s,
    input  logic  zc_evt,
    input  logic  unity_rel,
    input  logic  expire,
    output logic  start_o,
    output logic  pending_o,
    output db_t   stored_o,
    output db_t   gain_o
);
    db_t  new_db;
    db_t  target_db;
    logic request;
    logic resolve;

    // A request arises from a write or from releasing the override, and never while the override is held.
    always_comb begin
        new_db    = code_to_db(code_i);
        target_db = load_i ? new_db : stored_o;
        request   = (load_i | unity_rel) & ~unity_s;
        resolve   = pending_o & (zc_evt | expire | ~zc_en_s);
        start_o   = request & zc_en_s;
    end

    // Stored gain follows every write, including writes made under the override.
    always_ff @(posedge clk) begin
        if (!rst_n)      stored_o <= '0;
        else if (load_i) stored_o <= new_db;
    end

    // Applied gain and pending flag, updated by override, then request, then resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_o    <= '0;
            pending_o <= 1'b0;
        end else if (unity_s) begin
            gain_o    <= '0;
            pending_o <= 1'b0;
        end else if (request) begin
            if (zc_en_s) begin
                pending_o <= 1'b1;
            end else begin
                gain_o    <= target_db;
                pending_o <= 1'b0;
            end
        end else if (resolve) begin
            gain_o    <= stored_o;
            pending_o <= 1'b0;
        end
    end
endmodule

// File: rtl/zc_gain_ctrl.sv
// Module: zc_gain_ctrl (top)
// Gain update controller: synchronises the pins, detects sign changes and the
// override release, times out waiting changes and registers the applied gain.
// Assumes code_i/load_i are synchronous to clk and the other pins are asynchronous.
module zc_gain_ctrl #(
    parameter int TIMEOUT_CYC = 4_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] code_i,
    input  logic       load_i,
    input  logic       unity_i,
    input  logic       zc_en_i,
    input  logic       sign_i,
    output logic [6:0] gain_db_o
);
    import zcg_pkg::*;

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_s;
    logic unity_s, zc_en_s, sign_s;
    logic zc_evt, unity_rel, expire, start, pending;
    db_t  stored_db;
    db_t  gain_db;

    zcg_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({unity_i, zc_en_i, sign_i}),
        .q_o   (pins_s)
    );

    assign {unity_s, zc_en_s, sign_s} = pins_s;

    zcg_events u_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .sign_s      (sign_s),
        .unity_s     (unity_s),
        .zc_evt_o    (zc_evt),
        .unity_rel_o (unity_rel)
    );

    zcg_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .pending_i (pending),
        .expire_o  (expire)
    );

    zcg_update u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .code_i    (code_i),
        .unity_s   (unity_s),
        .zc_en_s   (zc_en_s),
        .zc_evt    (zc_evt),
        .unity_rel (unity_rel),
        .expire    (expire),
        .start_o   (start),
        .pending_o (pending),
        .stored_o  (stored_db),
        .gain_o    (gain_db)
    );

    assign gain_db_o = gain_db;
endmodule

// File: rtl/zc_gain_ctrl_chk.sv
// Module: zc_gain_ctrl_chk
// Checker bound into zc_gain_ctrl; relates the synchronised controls, the
// event signals and the applied gain across clock edges.
module zc_gain_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load_i,
    input logic       unity_s,
    input logic       zc_en_s,
    input logic       zc_evt,
    input logic       expire,
    input logic       pending,
    input logic [6:0] stored_db,
    input logic [6:0] gain_db_o
);
    // R1: the applied gain stays within the mapped range
    p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gain_db_o <= 7'(zcg_pkg::MAX_DB));

    // R2: immediate mode applies the stored gain on the write edge
    p_immediate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !unity_s && !zc_en_s) |=> (gain_db_o == stored_db));

    // R3: a pending change holds the output until a crossing or expiry
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && zc_en_s && !zc_evt && !expire && !unity_s) |=> $stable(gain_db_o));

    // R3: a crossing resolves the pending change to the stored gain
    p_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && zc_evt && !unity_s && !load_i) |=> (gain_db_o == stored_db && !pending));

    // R4: expiry resolves the pending change to the stored gain
    p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !unity_s && !load_i) |=> (gain_db_o == stored_db && !pending));

    // R6: the override forces 0 dB and drops pending work
    p_unity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        unity_s |=> (gain_db_o == 7'd0 && !pending));
endmodule

bind zc_gain_ctrl zc_gain_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_i),
    .unity_s   (unity_s),
    .zc_en_s   (zc_en_s),
    .zc_evt    (zc_evt),
    .expire    (expire),
    .pending   (pending),
    .stored_db (stored_db),
    .gain_db_o (gain_db_o)
);

// File: tb/zc_gain_ctrl_tb.sv
`timescale 1ns/1ps
module zc_gain_ctrl_tb;
    localparam int T = 40;
    localparam int NV = 10;
    // each entry: {code, expected dB}
    localparam logic [12:0] VEC [NV] = '{
        {6'd0, 7'd0},   {6'd1, 7'd10},  {6'd2, 7'd11},  {6'd17, 7'd26},
        {6'd30, 7'd39}, {6'd55, 7'd64}, {6'd56, 7'd65}, {6'd57, 7'd65},
        {6'd62, 7'd65}, {6'd63, 7'd65}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] code = '0;
    logic       load = 1'b0;
    logic       unity = 1'b0;
    logic       zc_en = 1'b0;
    logic       sign = 1'b0;
    logic [6:0] gain;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    zc_gain_ctrl #(.TIMEOUT_CYC(T), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .code_i(code), .load_i(load),
        .unity_i(unity), .zc_en_i(zc_en), .sign_i(sign), .gain_db_o(gain)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [6:0] exp);
        n_chk++;
        if (gain !== exp) begin
            n_bad++;
            $display("FAIL %s: gain actual %0d expected %0d", req, gain, exp);
        end
    endtask

    task automatic write(input logic [5:0] c);
        code = c;
        load = 1'b1;
        tick(1);
        load = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(3);
        rst_n = 1'b1;
        check("R10 reset", 7'd0);
        tick(4);
        check("R10 idle", 7'd0);

        // R1/R2 map table, immediate mode
        for (int i = 0; i < NV; i++) begin
            write(VEC[i][12:7]);
            check("R1 R2 map", VEC[i][6:0]);
        end

        // R3 rising crossing
        zc_en = 1'b1; tick(4);
        write(6'd20); tick(5);
        check("R3 held", 7'd65);
        sign = 1'b1; tick(2);
        check("R3 before edge", 7'd65);
        tick(1);
        check("R3 rising crossing", 7'd29);

        // R4 timeout
        write(6'd40); tick(T - 1);
        check("R4 before expiry", 7'd29);
        tick(1);
        check("R4 expiry", 7'd49);

        // R5 replacement restarts timer
        write(6'd10); tick(20);
        write(6'd12); tick(T - 1);
        check("R5 restarted", 7'd49);
        tick(1);
        check("R5 newer value", 7'd21);

        // R3 falling crossing
        write(6'd3); tick(2);
        sign = 1'b0; tick(2);
        check("R3 before falling", 7'd21);
        tick(1);
        check("R3 falling crossing", 7'd12);

        // R9 mode drop applies pending
        write(6'd30); tick(3);
        check("R9 pending", 7'd12);
        zc_en = 1'b0; tick(2);
        check("R9 before edge", 7'd12);
        tick(1);
        check("R9 mode drop", 7'd39);

        // R6/R7 override
        unity = 1'b1; tick(2);
        check("R6 before edge", 7'd39);
        tick(1);
        check("R6 forced", 7'd0);
        write(6'd5); tick(10);
        check("R7 write under override", 7'd0);

        // R8 release in zero-crossing mode
        zc_en = 1'b1; tick(4);
        unity = 1'b0; tick(8);
        check("R8 release held", 7'd0);
        sign = 1'b1; tick(2);
        check("R8 before crossing", 7'd0);
        tick(1);
        check("R8 R7 stored applied", 7'd14);

        // R8 release in immediate mode
        zc_en = 1'b0; tick(4);
        unity = 1'b1; tick(3);
        check("R6 forced again", 7'd0);
        write(6'd50); tick(2);
        unity = 1'b0; tick(2);
        check("R8 before release edge", 7'd0);
        tick(1);
        check("R8 R7 immediate release", 7'd59);

        // R10 reset mid-run
        rst_n = 1'b0; tick(1);
        check("R10 reset clears", 7'd0);
        rst_n = 1'b1; tick(2);
        check("R10 after reset", 7'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule